// File: doc/BRIEF.md
# Token Bucket Flow Regulator

This block meters one packet flow against a token bucket with a burst allowance (the bucket depth) and a sustained rate. Tokens build up every clock cycle at a programmable rate. The rate is a fixed-point tokens-per-cycle value, and its fractional part carries over from cycle to cycle. The count is capped at the programmed depth. One token pays for one byte, so over any window of t cycles the bytes let through never exceed the depth plus the rate times t.

The same bucket serves two modes, chosen by `mode_i`.

- **Policing** (`mode_i` = 0): each arriving packet descriptor receives a verdict on the next cycle. The packet is conforming if the bucket holds at least its length, and non-conforming otherwise.
- **Shaping** (`mode_i` = 1): descriptors wait in a small first-in first-out buffer. The head descriptor is released once the bucket can pay for it.

Only lengths pass through the block. Payload storage belongs to the surrounding datapath, which acts on the conform and release outputs. The mode should be changed only while the buffer is empty. Policing accepts nothing until the buffer has drained.

Top module: `token_regulator`

## Requirements
- R1: The first asynchronous reset leaves the bucket full: it holds `depth_i` tokens. After any reset, `verdict_valid_o` is low and the buffer is empty. A policed packet whose length equals the depth and that arrives right after the first reset is conforming.
- R2: Every cycle, `rate_i`/256 tokens are added. `rate_i` is unsigned fixed point whose low 8 bits are the fraction. Fractional tokens accumulate across cycles, so a rate below one token per cycle still lets packets through at the average rate.
- R3: The whole-token count never exceeds `depth_i`. Refill that would exceed it is discarded. After a long idle period, a packet one byte longer than the depth does not conform, and a packet exactly as long as the depth does.
- R4: In policing mode, `pkt_ready_o` is high exactly when the buffer is empty. An accepted packet produces `verdict_valid_o` = 1 and `verdict_len_o` equal to its length on the next cycle. `verdict_conform_o` is 1 exactly when the length is at most the whole-token count in the cycle of arrival.
- R5: A conforming packet removes exactly its length in tokens. A non-conforming packet removes none, so a later packet that fits still conforms.
- R6: In shaping mode, `pkt_ready_o` is high while the buffer holds fewer than QDEPTH descriptors. Each accepted length is stored.
- R7: In shaping mode, the head descriptor leaves the buffer in the first cycle, at least one cycle after it was written, in which the whole-token count is at least its length. The cycle after that, the block shows `verdict_valid_o` = 1, `verdict_conform_o` = 1 and the length. Release order is strictly the arrival order, and shaping never reports a non-conforming verdict.
- R8: Over any run of t cycles, the bytes reported as conforming or released are at most `depth_i` + `rate_i`·t/256.
- R9: When the buffer is full, `pkt_ready_o` is low and a presented packet is ignored. It is never released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = policing, 1 = shaping |
| rate_i | input | RATE_W (16) | Refill per cycle, 8 fractional bits |
| depth_i | input | TOK_W (16) | Bucket depth in whole tokens |
| pkt_valid_i | input | 1 | Packet descriptor offered |
| pkt_ready_o | output | 1 | Descriptor accepted this cycle when valid |
| pkt_len_i | input | LEN_W (12) | Packet length in bytes |
| verdict_valid_o | output | 1 | Verdict or release present |
| verdict_conform_o | output | 1 | 1 = conforming or released, 0 = non-conforming |
| verdict_len_o | output | LEN_W (12) | Length of the judged or released packet |

## Verification
Several events can fall in the same cycle. The head of the shaping buffer can be released while a new descriptor is written into it. Refill can hit the depth cap in the same cycle as a spend. A policed arrival can be judged in the same cycle the bucket is refilled. The bench provokes these cases with back-to-back arrivals at rates above and below one token per cycle, and by offering packets while the buffer is full and while its head is draining. A behavioural model with a length queue and an integer token count, scaled by 256, predicts every cycle's verdict and ready signal. Any mismatch in either is a failure.

// File: rtl/token_regulator_pkg.sv
package token_regulator_pkg;
  typedef enum logic {
    MODE_POLICE = 1'b0,
    MODE_SHAPE  = 1'b1
  } reg_mode_e;
endpackage

// File: rtl/token_bucket.sv
module token_bucket #(
  parameter int TOK_W  = 16,
  parameter int FRAC_W = 8,
  parameter int RATE_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TOK_W-1:0]  depth_i,
  input  logic [LEN_W-1:0]  spend_i,
  output logic [TOK_W-1:0]  tok_o
);
  localparam int ACC_W = TOK_W + FRAC_W;
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, cap, eff;
  logic [SUM_W-1:0] sum;

  assign cap   = {depth_i, {FRAC_W{1'b0}}};
  // all-ones reset value clamps to a full bucket whatever the depth
  assign eff   = (acc_q > cap) ? cap : acc_q;
  assign tok_o = eff[ACC_W-1:FRAC_W];

  assign sum   = SUM_W'(eff) - (SUM_W'(spend_i) << FRAC_W) + SUM_W'(rate_i);
  assign acc_d = (sum > SUM_W'(cap)) ? cap : sum[ACC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '1;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign cnt_o   = cnt_q;
  assign head_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/token_regulator.sv
module token_regulator
  import token_regulator_pkg::*;
#(
  parameter int TOK_W  = 16,
  parameter int FRAC_W = 8,
  parameter int RATE_W = 16,
  parameter int LEN_W  = 12,
  parameter int QDEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [TOK_W-1:0]  depth_i,
  input  logic              pkt_valid_i,
  output logic              pkt_ready_o,
  input  logic [LEN_W-1:0]  pkt_len_i,
  output logic              verdict_valid_o,
  output logic              verdict_conform_o,
  output logic [LEN_W-1:0]  verdict_len_o
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  reg_mode_e        mode;
  logic [TOK_W-1:0] tok;
  logic [LEN_W-1:0] spend, head_len;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_empty, fifo_full;
  logic             accept, rel, pol, pol_ok;
  logic             vv_q, vc_q;
  logic [LEN_W-1:0] vl_q;

  assign mode        = reg_mode_e'(mode_i);
  assign pkt_ready_o = (mode == MODE_SHAPE) ? !fifo_full : fifo_empty;
  assign accept      = pkt_valid_i && pkt_ready_o;

  // head is only eligible from stored entries, never bypassed
  assign rel    = !fifo_empty && (TOK_W'(head_len) <= tok);
  assign pol    = accept && (mode == MODE_POLICE);
  assign pol_ok = pol && (TOK_W'(pkt_len_i) <= tok);
  assign spend  = rel ? head_len : (pol_ok ? pkt_len_i : '0);

  token_bucket #(
    .TOK_W(TOK_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W), .LEN_W(LEN_W)
  ) u_bucket (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_i),
    .depth_i (depth_i),
    .spend_i (spend),
    .tok_o   (tok)
  );

  desc_fifo #(
    .DEPTH(QDEPTH), .W(LEN_W)
  ) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept && (mode == MODE_SHAPE)),
    .data_i  (pkt_len_i),
    .pop_i   (rel),
    .head_o  (head_len),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vv_q <= 1'b0;
      vc_q <= 1'b0;
      vl_q <= '0;
    end else begin
      vv_q <= rel || pol;
      vc_q <= rel || pol_ok;
      if (rel || pol) vl_q <= rel ? head_len : pkt_len_i;
    end
  end

  assign verdict_valid_o   = vv_q;
  assign verdict_conform_o = vc_q;
  assign verdict_len_o     = vl_q;
endmodule

// File: rtl/token_regulator_chk.sv
module token_regulator_chk #(
  parameter int TOK_W  = 16,
  parameter int LEN_W  = 12,
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic [TOK_W-1:0] depth_i,
  input logic             pkt_valid_i,
  input logic             pkt_ready_o,
  input logic [LEN_W-1:0] pkt_len_i,
  input logic             verdict_valid_o,
  input logic             verdict_conform_o,
  input logic [LEN_W-1:0] verdict_len_o,
  input logic [TOK_W-1:0] tok,
  input logic [LEN_W-1:0] spend,
  input logic [CNT_W-1:0] fifo_cnt
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  AST_POLICE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && pkt_valid_i && pkt_ready_o) |=>
      (verdict_valid_o && verdict_len_o == $past(pkt_len_i))); // R4

  AST_POLICE_WAITS_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && fifo_cnt != '0) |-> !pkt_ready_o); // R4

  AST_SHAPE_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && verdict_valid_o && !verdict_conform_o) |-> !$past(mode_i)); // R7

  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CNT_W'(QDEPTH)) |-> !pkt_ready_o); // R9

  AST_PAID_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && verdict_valid_o && verdict_conform_o) |->
      ($past(tok) >= TOK_W'(verdict_len_o))); // R5

  AST_REFILL_MONOTONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && $past(spend) == '0 && $stable(depth_i)) |-> (tok >= $past(tok))); // R2
endmodule

bind token_regulator token_regulator_chk #(
  .TOK_W(TOK_W), .LEN_W(LEN_W), .QDEPTH(QDEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .mode_i            (mode_i),
  .depth_i           (depth_i),
  .pkt_valid_i       (pkt_valid_i),
  .pkt_ready_o       (pkt_ready_o),
  .pkt_len_i         (pkt_len_i),
  .verdict_valid_o   (verdict_valid_o),
  .verdict_conform_o (verdict_conform_o),
  .verdict_len_o     (verdict_len_o),
  .tok               (tok),
  .spend             (spend),
  .fifo_cnt          (fifo_cnt)
);

// File: tb/token_regulator_tb.sv
`timescale 1ns/1ps
module token_regulator_tb;
  localparam int QD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [15:0] rate = 16'h0100;
  logic [15:0] depth = 16'd100;
  logic        pv = 1'b0;
  logic        prdy;
  logic [11:0] plen = '0;
  logic        vv, vc;
  logic [11:0] vl;

  always #5 clk = ~clk;

  token_regulator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .rate_i(rate), .depth_i(depth),
    .pkt_valid_i(pv), .pkt_ready_o(prdy), .pkt_len_i(plen),
    .verdict_valid_o(vv), .verdict_conform_o(vc), .verdict_len_o(vl)
  );

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";

  // behavioural model: token count scaled by 256, queue of lengths
  longint tok_m = 64'h4000_0000;
  int     q[$];
  logic   exp_v = 1'b0, exp_c = 1'b0;
  int     exp_l = 0;
  bit     meter = 1'b0;
  longint rel_bytes = 0, win_cyc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      exp_v = 1'b0;
    end else begin
      longint cap, eff, spend;
      int     ti;
      bit     rdy;
      cap   = longint'(depth) * 256;
      eff   = (tok_m > cap) ? cap : tok_m;
      ti    = int'(eff / 256);
      rdy   = mode ? (q.size() < QD) : (q.size() == 0);
      spend = 0;
      exp_v = 1'b0;
      if (q.size() > 0 && q[0] <= ti) begin
        exp_v = 1'b1; exp_c = 1'b1; exp_l = q[0]; spend = q[0];
        void'(q.pop_front());
      end else if (!mode && pv && rdy) begin
        exp_v = 1'b1; exp_l = int'(plen);
        exp_c = (int'(plen) <= ti);
        spend = exp_c ? longint'(plen) : 0;
      end
      if (mode && pv && rdy) q.push_back(int'(plen));
      tok_m = eff - spend * 256 + longint'(rate);
      if (tok_m > cap) tok_m = cap;
      if (meter) begin
        win_cyc++;
        if (exp_v && exp_c) rel_bytes += longint'(exp_l);
      end
    end
  end

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic compare();
    bit r_exp;
    r_exp = mode ? (q.size() < QD) : (q.size() == 0);
    chk(prdy == r_exp, (q.size() == QD) ? "R9" : tag, "ready", int'(prdy), int'(r_exp));
    chk(vv == exp_v, tag, "verdict_valid", int'(vv), int'(exp_v));
    if (exp_v && vv) begin
      chk(vc == exp_c, tag, "conform", int'(vc), int'(exp_c));
      chk(int'(vl) == exp_l, tag, "length", int'(vl), exp_l);
    end
  endtask

  task automatic cyc(input bit v, input int len);
    pv = v; plen = 12'(len);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 100000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(vv == 1'b0, "R1", "verdict_valid in reset", int'(vv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    chk(prdy == 1'b1, "R1", "ready after reset", int'(prdy), 1);
    tag = "R1";
    cyc(1'b1, 100);   // full bucket pays whole depth
    idle(1);
    // R5: nonconforming packet spends nothing
    tag = "R5";
    cyc(1'b1, 50);
    cyc(1'b1, 2);
    idle(2);
    // R2: fractional rate accumulation
    tag = "R2"; rate = 16'h0040;
    for (int i = 0; i < 40; i++) cyc(1'b1, 3);
    // R3: cap after long idle
    tag = "R3"; rate = 16'h0300;
    idle(200);
    cyc(1'b1, 101);
    cyc(1'b1, 100);
    idle(1);
    // R4: back-to-back policing with random lengths
    tag = "R4"; rate = 16'h0180;
    for (int i = 0; i < 60; i++) cyc(1'b1, $urandom_range(0, 40));
    idle(2);
    // R6/R7: shaping, FIFO order
    tag = "R7"; rate = 16'h0080; mode = 1'b1;
    cyc(1'b1, 90); cyc(1'b1, 20); cyc(1'b1, 5); cyc(1'b1, 30);
    tag = "R6";
    idle(300);
    // R9: full buffer ignores arrivals
    tag = "R9"; rate = 16'h0010;
    for (int i = 0; i < 10; i++) cyc(1'b1, 30);
    idle(1500);
    // R8: saturated shaping window bound
    tag = "R8"; rate = 16'h00C0;
    meter = 1'b1; rel_bytes = 0; win_cyc = 0;
    for (int i = 0; i < 400; i++) cyc(1'b1, $urandom_range(1, 20));
    begin
      longint bound;
      bound = longint'(depth) + (longint'(rate) * win_cyc) / 256;
      chk(rel_bytes <= bound, "R8", "released bytes within bound", int'(rel_bytes), int'(bound));
    end
    meter = 1'b0;
    tag = "R7";
    idle(200);
    // back to policing after drain
    tag = "R4"; mode = 1'b0; rate = 16'h0100;
    for (int i = 0; i < 20; i++) cyc(1'b1, $urandom_range(0, 8));
    idle(2);
    finish_run();
  end
endmodule